// File: doc/BRIEF.md
# Supervisory Reset Generator with Watchdog

This block drives the reset line of a host processor. It combines three reset sources: an undervoltage flag from an external supply comparator (already synchronized to the block clock), an active-low push-button or logic-driven manual reset, and a watchdog that the host must service by toggling a line. The block stretches every reset request by a fixed hold time. The hold time and the watchdog timeout are both counted in units of a prescaled tick (nominally 1 kHz) and are set by parameters.

The manual reset and watchdog lines arrive asynchronously and pass through a multi-stage synchronizer. Either edge of the synchronized watchdog line restarts the watchdog count. The count is frozen at zero for as long as reset is active. No input setting can switch the watchdog off. When the watchdog line stays stuck, the output therefore carries a train of reset pulses, and each period is the timeout plus the hold time. The block provides the reset in both polarities, each from its own register.

Top module: `sup_rst_gen`

## Requirements
- R1: After the asynchronous block reset, the reset output is asserted (rst_n_o = 0) and releases only after HOLD_TICKS tick pulses have been counted with no reset source active.
- R2: While uv_i is high, reset is asserted, starting at the first clock edge that samples uv_i high.
- R3: After the last active reset source clears, reset stays asserted until HOLD_TICKS ticks have been seen. It releases at the edge that samples the final tick.
- R4: A new undervoltage request during the hold period restarts the hold count from zero, so the reset is extended.
- R5: A low level on mrst_n_i, seen after SYNC_STAGES clock edges of synchronization, asserts reset. Reset holds while the input stays low and for HOLD_TICKS ticks after it returns high.
- R6: A rising or a falling transition of the synchronized wd_i clears the watchdog count. Toggling wd_i at intervals shorter than the timeout never causes a reset.
- R7: If WD_TICKS ticks pass with no wd_i transition while reset is released, the watchdog expires and produces a reset that lasts HOLD_TICKS ticks.
- R8: The watchdog count is held at zero while reset is asserted, and no input setting disables the watchdog. A stuck wd_i therefore gives periodic resets of about WD_TICKS plus HOLD_TICKS ticks.
- R9: rst_o is the exact inverse of rst_n_o on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | One-cycle pulse at the prescaled timebase rate |
| uv_i | input | 1 | Synchronized undervoltage flag, high means supply below threshold |
| mrst_n_i | input | 1 | Asynchronous active-low manual reset request |
| wd_i | input | 1 | Asynchronous watchdog service line from the host |
| rst_n_o | output | 1 | Active-low reset to the host |
| rst_o | output | 1 | Active-high reset, inverse of rst_n_o |

## Verification
A hold counter in the wrong state shows at the ports as a reset edge one or more ticks early or late. A shadow model that follows the output every cycle catches this at the release edge itself. A watchdog count that is not cleared by an edge, or that keeps running during reset, shows as a reset pulse in a phase where the host services the line, or as a pulse period shorter than timeout plus hold. In both cases the fault appears within one timeout window. A synchronizer of the wrong depth moves the manual reset assertion by whole cycles, and the per-cycle comparison catches this on the first request.

// File: rtl/sup_rst_pkg.sv
package sup_rst_pkg;

   // Bits needed to hold the values 0..limit inclusive
   function automatic int cnt_bits(input int limit);
      return (limit < 1) ? 1 : $clog2(limit + 1);
   endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
   parameter int              WIDTH   = 2,
   parameter int              STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("sup_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] pipe_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) pipe_q <= {STAGES{RST_VAL}};
      else         pipe_q <= {pipe_q[STAGES-2:0], d};
   end

   assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer
   import sup_rst_pkg::*;
#(
   parameter int HOLD_TICKS = 200
) (
   input  logic clk,
   input  logic arst_n,
   input  logic tick,
   input  logic trig,
   output logic rst_n_o,
   output logic rst_o
);

   localparam int            CW   = cnt_bits(HOLD_TICKS);
   localparam logic [CW-1:0] DONE = CW'(HOLD_TICKS);

   logic [CW-1:0] cnt_q, cnt_d;
   logic          rst_n_q, rst_hi_q;

   always_comb begin
      cnt_d = cnt_q;
      if (trig)                     cnt_d = '0;
      else if (tick && cnt_q != DONE) cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         cnt_q    <= '0;
         rst_n_q  <= 1'b0;
         rst_hi_q <= 1'b1;
      end else begin
         cnt_q    <= cnt_d;
         rst_n_q  <= (cnt_d == DONE);
         rst_hi_q <= (cnt_d != DONE);
      end
   end

   assign rst_n_o = rst_n_q;
   assign rst_o   = rst_hi_q;

endmodule

// File: rtl/sup_wd_timer.sv
module sup_wd_timer
   import sup_rst_pkg::*;
#(
   parameter int WD_TICKS = 1600,
   localparam int CW      = cnt_bits(WD_TICKS)
) (
   input  logic          clk,
   input  logic          arst_n,
   input  logic          tick,
   input  logic          wd_s,
   input  logic          rst_act,
   output logic          expire,
   output logic [CW-1:0] wd_cnt
);

   localparam logic [CW-1:0] LIMIT = CW'(WD_TICKS);

   logic          prev_q;
   logic          wd_edge;
   logic [CW-1:0] cnt_q, cnt_d;

   assign wd_edge = wd_s ^ prev_q;

   always_comb begin
      cnt_d = cnt_q;
      if (rst_act || wd_edge)          cnt_d = '0;
      else if (tick && cnt_q != LIMIT) cnt_d = cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         prev_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         prev_q <= wd_s;
         cnt_q  <= cnt_d;
      end
   end

   assign expire = (cnt_q == LIMIT);
   assign wd_cnt = cnt_q;

endmodule

// File: rtl/sup_rst_gen.sv
module sup_rst_gen
   import sup_rst_pkg::*;
#(
   parameter int HOLD_TICKS  = 200,
   parameter int WD_TICKS    = 1600,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic tick_i,
   input  logic uv_i,
   input  logic mrst_n_i,
   input  logic wd_i,
   output logic rst_n_o,
   output logic rst_o
);

   localparam int WD_CW = cnt_bits(WD_TICKS);

   if (HOLD_TICKS < 1) begin : g_bad_hold
      $error("sup_rst_gen: HOLD_TICKS must be at least 1");
   end
   if (WD_TICKS < 1) begin : g_bad_wd
      $error("sup_rst_gen: WD_TICKS must be at least 1");
   end

   logic [1:0]       sync_q;
   logic             mr_sync, wd_sync;
   logic             wd_expire;
   logic [WD_CW-1:0] wd_cnt;
   logic             trig;

   // bit 1: manual reset (idles high), bit 0: watchdog line
   sup_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES),
      .RST_VAL(2'b10)
   ) u_sync (
      .clk   (clk),
      .arst_n(arst_n),
      .d     ({mrst_n_i, wd_i}),
      .q     (sync_q)
   );

   assign mr_sync = sync_q[1];
   assign wd_sync = sync_q[0];

   assign trig = uv_i | ~mr_sync | wd_expire;

   sup_hold_timer #(
      .HOLD_TICKS(HOLD_TICKS)
   ) u_hold (
      .clk    (clk),
      .arst_n (arst_n),
      .tick   (tick_i),
      .trig   (trig),
      .rst_n_o(rst_n_o),
      .rst_o  (rst_o)
   );

   sup_wd_timer #(
      .WD_TICKS(WD_TICKS)
   ) u_wd (
      .clk    (clk),
      .arst_n (arst_n),
      .tick   (tick_i),
      .wd_s   (wd_sync),
      .rst_act(~rst_n_o),
      .expire (wd_expire),
      .wd_cnt (wd_cnt)
   );

endmodule

// File: rtl/sup_rst_chk.sv
module sup_rst_chk #(
   parameter int WD_CW = 11
) (
   input logic             clk,
   input logic             arst_n,
   input logic             tick_i,
   input logic             uv_i,
   input logic             mr_sync,
   input logic             wd_expire,
   input logic [WD_CW-1:0] wd_cnt,
   input logic             rst_n_o,
   input logic             rst_o
);

   AST_UV_ASSERTS: assert property (@(posedge clk) disable iff (!arst_n)
      uv_i |=> !rst_n_o); // R2

   AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(rst_n_o) |-> ($past(tick_i) && !$past(uv_i) && $past(mr_sync))); // R3

   AST_MANUAL_ASSERTS: assert property (@(posedge clk) disable iff (!arst_n)
      !mr_sync |=> !rst_n_o); // R5

   AST_EXPIRE_RESETS: assert property (@(posedge clk) disable iff (!arst_n)
      wd_expire |=> !rst_n_o); // R7

   AST_WD_HELD_IN_RESET: assert property (@(posedge clk) disable iff (!arst_n)
      !rst_n_o |=> (wd_cnt == '0)); // R8

   AST_POLARITY_PAIR: assert property (@(posedge clk) disable iff (!arst_n)
      rst_o != rst_n_o); // R9

endmodule

bind sup_rst_gen sup_rst_chk #(.WD_CW(WD_CW)) u_chk (
   .clk      (clk),
   .arst_n   (arst_n),
   .tick_i   (tick_i),
   .uv_i     (uv_i),
   .mr_sync  (mr_sync),
   .wd_expire(wd_expire),
   .wd_cnt   (wd_cnt),
   .rst_n_o  (rst_n_o),
   .rst_o    (rst_o)
);

// File: tb/sup_rst_gen_bench.sv
module sup_rst_gen_bench;

   localparam int HOLD     = 5;
   localparam int WDT      = 12;
   localparam int TICK_DIV = 4;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic tick_i = 1'b0;
   logic uv_i = 1'b0;
   logic mrst_n_i = 1'b1;
   logic wd_i = 1'b0;
   logic rst_n_o, rst_o;

   int n_cmp = 0;
   int n_bad = 0;
   int tick_ctr = 0;
   int wd_gap = 0;    // 0: line left alone, else toggle every wd_gap cycles
   int wd_ctr = 0;
   int pulses = 0;
   logic last_rst = 1'b1;
   string tag = "R1";

   always #4 clk = ~clk; // 125 MHz

   sup_rst_gen #(.HOLD_TICKS(HOLD), .WD_TICKS(WDT), .SYNC_STAGES(2)) u_sup_rst_gen (
      .clk(clk), .arst_n(arst_n), .tick_i(tick_i), .uv_i(uv_i),
      .mrst_n_i(mrst_n_i), .wd_i(wd_i), .rst_n_o(rst_n_o), .rst_o(rst_o)
   );

   // Behavioural expectation: request pipeline, elapsed ticks since last request
   int   quiet_ticks;   // ticks seen since last request, capped at HOLD
   int   idle_ticks;    // ticks since last service or reset, capped at WDT
   logic mr_q[$];
   logic wd_q[$];
   logic wd_seen;
   logic in_reset;

   always @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         quiet_ticks = 0; idle_ticks = 0;
         mr_q = '{1'b1, 1'b1}; wd_q = '{1'b0, 1'b0};
         wd_seen = 1'b0; in_reset = 1'b1;
      end else begin
         logic mr_now, wd_now, request, serviced;
         int q_next, i_next;
         mr_now  = mr_q[0];
         wd_now  = wd_q[0];
         request = uv_i || !mr_now || (idle_ticks == WDT);
         serviced = (wd_now != wd_seen);
         if (request) q_next = 0;
         else q_next = (tick_i && quiet_ticks < HOLD) ? quiet_ticks + 1 : quiet_ticks;
         if (in_reset || serviced) i_next = 0;
         else i_next = (tick_i && idle_ticks < WDT) ? idle_ticks + 1 : idle_ticks;
         wd_seen = wd_now;
         void'(mr_q.pop_front()); mr_q.push_back(mrst_n_i);
         void'(wd_q.pop_front()); wd_q.push_back(wd_i);
         quiet_ticks = q_next;
         idle_ticks  = i_next;
         in_reset    = (quiet_ticks < HOLD);
      end
   end

   task automatic check(input string req, input logic got, input logic exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
      end
   endtask

   task automatic run(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         @(negedge clk);
         check(tag, rst_n_o, !in_reset);
         check("R9", rst_o, !rst_n_o);
         if (rst_o && !last_rst) pulses++;
         last_rst = rst_o;
         tick_ctr = (tick_ctr + 1) % TICK_DIV;
         tick_i = (tick_ctr == 0);
         if (wd_gap > 0) begin
            wd_ctr++;
            if (wd_ctr >= wd_gap) begin wd_ctr = 0; wd_i = ~wd_i; end
         end
      end
   endtask

   initial begin : watchdog_timer
      #(8 * 20000);
      n_bad++;
      $display("FAIL watchdog: run hung, got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", rst_n_o, 1'b0);
      check("R1", rst_o, 1'b1);
      arst_n = 1'b1;
      tag = "R1"; wd_gap = 20;
      run(60);
      check("R1", rst_n_o, 1'b1);

      tag = "R2"; uv_i = 1'b1; run(12);
      check("R2", rst_n_o, 1'b0);
      tag = "R3"; uv_i = 1'b0; run(40);
      check("R3", rst_n_o, 1'b1);

      tag = "R4"; uv_i = 1'b1; run(2); uv_i = 1'b0; run(9);
      uv_i = 1'b1; run(1); uv_i = 1'b0; run(14);
      check("R4", rst_n_o, 1'b0);
      run(30);

      tag = "R5"; mrst_n_i = 1'b0; run(15);
      check("R5", rst_n_o, 1'b0);
      mrst_n_i = 1'b1; run(40);
      check("R5", rst_n_o, 1'b1);

      tag = "R6"; pulses = 0; wd_gap = 30; run(400);
      check("R6", pulses > 0, 1'b0);

      tag = "R7"; pulses = 0; wd_gap = 0; run(70);
      check("R7", pulses >= 1, 1'b1);
      tag = "R8"; pulses = 0; run(400);
      // period (WDT+HOLD)*TICK_DIV = 68 cycles, so about 5-6 pulses
      check("R8", (pulses >= 5) && (pulses <= 7), 1'b1);

      tag = "R8"; mrst_n_i = 1'b1; uv_i = 1'b0; wd_i = 1'b1; run(200);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule